// File: doc/BRIEF.md
# MII Transmit Frame Monitor

This block observes the transmit side of a 4-bit media-independent interface. It runs on the transmit clock and does not drive the link. It checks one protocol rule: a collision must always come with carrier sense. Each kind of violation sets its own bit in a sticky error vector. The block also measures the octet length of every frame that ends without a collision. It flags a collision that arrives on the last nibble of a frame.

A verification environment connects the monitor to the transmit pins of the interface under test and reads its flags. By default the first error blocks the monitor. While blocked, it records no further failures and raises no frame strobes or coverage events. A single-cycle clear pulse zeroes the vector and restarts frame tracking. A frame that is already under way at that moment is skipped, and measurement resumes at the next rising edge of transmit enable.

Top module: `mii_tx_monitor`

## Requirements
- R1: After reset the error vector is zero, the frame strobe is low and both coverage bits are low.
- R2: A cycle with collision high and carrier sense low sets error bit 0, visible one cycle later, when the monitor is not blocked.
- R3: Error bits are sticky. A bit stays set until a clear or a reset. Failures detected in the same cycle are all ORed into the vector.
- R4: With the default blocking parameter, a non-zero error vector suppresses every further error, frame strobe and coverage event.
- R5: A clear pulse zeroes the whole error vector in the next cycle. Checking resumes from the cycle after the clear.
- R6: A frame starts on a rising edge of transmit enable and ends at the first cycle with it low. A collision-free frame raises the frame strobe for one cycle, one cycle after that low cycle. The length output carries the nibble count divided by two, rounded down.
- R7: A collision-free frame with an odd nibble count sets error bit 1 at the same moment as its strobe.
- R8: A frame in which a collision is seen on any nibble produces no frame strobe.
- R9: Coverage bit 0 pulses at a frame's end when the collision fell on its last nibble, and not otherwise.
- R10: Coverage bit 1 pulses once for each in-frame cycle that has a collision.
- R11: A frame already in progress when a clear arrives yields no strobe. The next frame is measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the link |
| col_i | input | 1 | Collision indication |
| crs_i | input | 1 | Carrier sense |
| clr_i | input | 1 | One-cycle clear of error flags and frame tracking |
| err_o | output | 2 | Sticky errors: bit 0 collision without carrier, bit 1 odd nibble count |
| frame_done_o | output | 1 | One-cycle strobe for a measured frame |
| frame_len_o | output | CNT_W-1 | Length in octets of the last measured frame |
| cov_o | output | 2 | Coverage pulses: bit 0 last-nibble collision, bit 1 in-frame collision |

## Verification
The hardest cases to reach from the ports are the ones where two events land on the same edge. One is a frame end with an odd nibble count that falls in the same cycle as a carrier-less collision, so two error bits arrive together. The other is a clear that lands in the middle of a frame, so the frame's end must be ignored. Directed sequences line these up cycle by cycle on the falling clock edge. Randomly sized collision-free frames then sweep the lengths, and a clear follows every odd-length frame so that blocking does not end the sweep.

// File: rtl/mii_tx_mon_pkg.sv
package mii_tx_mon_pkg;
  localparam int ERR_W = 2;
  localparam int COV_W = 2;
  localparam int ERR_COL_NO_CRS = 0;
  localparam int ERR_ODD_LEN    = 1;
  localparam int COV_LAST_NIB   = 0;
  localparam int COV_COL_FRAME  = 1;
endpackage

// File: rtl/mii_tx_err_reg.sv
module mii_tx_err_reg #(
  parameter int ERR_W        = 2,
  parameter bit BLOCK_ON_ERR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ERR_W-1:0] set_i,
  output logic [ERR_W-1:0] err_o,
  output logic             block_o
);
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= '0;
    else if (clr_i)    err_q <= '0;
    else if (!block_o) err_q <= err_q | set_i;
  end

  generate
    if (BLOCK_ON_ERR) begin : g_block
      assign block_o = |err_q;
    end else begin : g_noblock
      assign block_o = 1'b0;
    end
  endgenerate

  assign err_o = err_q;
endmodule

// File: rtl/mii_tx_frame_trk.sv
module mii_tx_frame_trk #(
  parameter int CNT_W = 12,
  parameter int COV_W = 2,
  localparam int LEN_W = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             tx_en_i,
  input  logic             col_i,
  output logic             odd_end_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic [COV_W-1:0] cov_o
);
  logic             prev_en_q, in_frame_q, col_seen_q, col_last_q;
  logic [CNT_W-1:0] nib_q;
  logic             rise, end_evt, clean_end;

  assign rise      = tx_en_i & ~prev_en_q;
  assign end_evt   = in_frame_q & ~tx_en_i;
  assign clean_end = end_evt & ~col_seen_q;
  assign odd_end_o = clean_end & nib_q[0] & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_en_q  <= 1'b1;  // frame in flight at reset is skipped
      in_frame_q <= 1'b0;
      col_seen_q <= 1'b0;
      col_last_q <= 1'b0;
      nib_q      <= '0;
      done_o     <= 1'b0;
      len_o      <= '0;
      cov_o      <= '0;
    end else begin
      prev_en_q <= tx_en_i;
      done_o    <= 1'b0;
      cov_o     <= '0;
      if (hold_i) begin
        in_frame_q <= 1'b0;
        col_seen_q <= 1'b0;
        col_last_q <= 1'b0;
      end else if (rise) begin
        in_frame_q <= 1'b1;
        nib_q      <= CNT_W'(1);
        col_seen_q <= col_i;
        col_last_q <= col_i;
        cov_o[1]   <= col_i;
      end else if (in_frame_q && tx_en_i) begin
        if (nib_q != '1) nib_q <= nib_q + 1'b1;
        col_seen_q <= col_seen_q | col_i;
        col_last_q <= col_i;
        cov_o[1]   <= col_i;
      end else if (end_evt) begin
        in_frame_q <= 1'b0;
        cov_o[0]   <= col_last_q;
        if (clean_end) begin
          done_o <= 1'b1;
          len_o  <= nib_q[CNT_W-1:1];
        end
      end
    end
  end
endmodule

// File: rtl/mii_tx_monitor.sv
module mii_tx_monitor
  import mii_tx_mon_pkg::*;
#(
  parameter bit BLOCK_ON_ERR = 1'b1,
  parameter int CNT_W        = 12,
  localparam int LEN_W       = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             col_i,
  input  logic             crs_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] err_o,
  output logic             frame_done_o,
  output logic [LEN_W-1:0] frame_len_o,
  output logic [COV_W-1:0] cov_o
);
  logic             block, odd_end;
  logic [ERR_W-1:0] err_set;

  always_comb begin
    err_set                 = '0;
    err_set[ERR_COL_NO_CRS] = col_i & ~crs_i;
    err_set[ERR_ODD_LEN]    = odd_end;
  end

  mii_tx_err_reg #(.ERR_W(ERR_W), .BLOCK_ON_ERR(BLOCK_ON_ERR)) u_err (
    .clk_i, .rst_ni, .clr_i,
    .set_i  (err_set),
    .err_o  (err_o),
    .block_o(block)
  );

  mii_tx_frame_trk #(.CNT_W(CNT_W), .COV_W(COV_W)) u_trk (
    .clk_i, .rst_ni,
    .hold_i   (clr_i | block),
    .tx_en_i,
    .col_i,
    .odd_end_o(odd_end),
    .done_o   (frame_done_o),
    .len_o    (frame_len_o),
    .cov_o    (cov_o)
  );
endmodule

// File: rtl/mii_tx_monitor_chk.sv
module mii_tx_monitor_chk
  import mii_tx_mon_pkg::*;
#(
  parameter bit BLOCK_ON_ERR = 1'b1,
  parameter int CNT_W        = 12,
  localparam int LEN_W       = CNT_W - 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             col_i,
  input logic             crs_i,
  input logic             clr_i,
  input logic [ERR_W-1:0] err_o,
  input logic             frame_done_o,
  input logic [LEN_W-1:0] frame_len_o,
  input logic [COV_W-1:0] cov_o
);
  logic blocked;
  assign blocked = BLOCK_ON_ERR && (|err_o);

  AST_COL_NEEDS_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_i && !crs_i && !blocked && !clr_i) |=> err_o[ERR_COL_NO_CRS]); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_o & $past(err_o)) == $past(err_o))); // R3
  AST_BLOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> (!frame_done_o && cov_o == '0)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_o == '0)); // R5
  AST_DONE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (!$past(tx_en_i) && $past(tx_en_i, 2))); // R6
  AST_COL_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cov_o[COV_LAST_NIB] |-> !frame_done_o); // R8
endmodule

bind mii_tx_monitor mii_tx_monitor_chk #(.BLOCK_ON_ERR(BLOCK_ON_ERR), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_mii_tx_monitor.sv
`timescale 1ns/1ps
module tb_mii_tx_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0, col = 1'b0, crs = 1'b0, clr = 1'b0;
  logic [1:0]  err;
  logic        done;
  logic [10:0] len;
  logic [1:0]  cov;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, cov0_cnt = 0, cov1_cnt = 0;
  int last_len = -1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mii_tx_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .col_i(col), .crs_i(crs),
    .clr_i(clr), .err_o(err), .frame_done_o(done), .frame_len_o(len), .cov_o(cov)
  );

  always @(posedge clk) begin
    #1;
    if (done) begin done_cnt++; last_len = int'(len); end
    if (cov[0]) cov0_cnt++;
    if (cov[1]) cov1_cnt++;
  end

  function automatic int exp_len(int n); return n / 2; endfunction
  function automatic int exp_err(int n); return (n % 2 == 1) ? 2 : 0; endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic zero_cnt();
    done_cnt = 0; cov0_cnt = 0; cov1_cnt = 0; last_len = -1;
  endtask

  task automatic drive(bit en, bit c, bit cs, bit cl);
    @(negedge clk);
    tx_en = en; col = c; crs = cs; clr = cl;
  endtask

  task automatic send_frame(int n, int col_at, int clr_at);
    for (int i = 0; i < n; i++) drive(1'b1, i == col_at, 1'b1, i == clr_at);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_clear();
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 err", int'(err), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cov", int'(cov), 0);

    // R6 directed even frames
    zero_cnt(); send_frame(8, -1, -1);
    chk("R6 strobes", done_cnt, 1);
    chk("R6 len", last_len, 4);
    chk("R6 err", int'(err), 0);
    zero_cnt(); send_frame(2, -1, -1);
    chk("R6 short len", last_len, 1);

    // R7 odd frame
    zero_cnt(); send_frame(5, -1, -1);
    chk("R7 len", last_len, 2);
    chk("R7 err", int'(err), 2);
    do_clear();
    chk("R5 clear after odd", int'(err), 0);

    // R8, R9, R10: collision on last nibble
    zero_cnt(); send_frame(6, 5, -1);
    chk("R8 no strobe", done_cnt, 0);
    chk("R9 last nibble cov", cov0_cnt, 1);
    chk("R10 col cov", cov1_cnt, 1);
    chk("R8 err", int'(err), 0);
    // R9 collision mid-frame
    zero_cnt(); send_frame(6, 2, -1);
    chk("R9 mid col no cov0", cov0_cnt, 0);
    chk("R10 mid col cov1", cov1_cnt, 1);
    chk("R8 mid col no strobe", done_cnt, 0);
    // R10 collision on first nibble, odd length: no odd error
    zero_cnt(); send_frame(3, 0, -1);
    chk("R10 first nibble cov1", cov1_cnt, 1);
    chk("R8 odd col frame err", int'(err), 0);

    // R2 collision without carrier, outside a frame
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 err bit0", int'(err), 1);
    // R3 sticky
    repeat (20) drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 sticky", int'(err), 1);
    // R4 blocked: frame with collision, then odd clean frame
    zero_cnt(); send_frame(6, 5, -1); send_frame(5, -1, -1);
    chk("R4 no strobe", done_cnt, 0);
    chk("R4 no cov", cov0_cnt + cov1_cnt, 0);
    chk("R4 no new err", int'(err), 1);
    do_clear();
    chk("R5 clear", int'(err), 0);
    zero_cnt(); send_frame(4, -1, -1);
    chk("R5 resumes", last_len, 2);

    // R3 two failures on the same edge: odd frame ends with carrier-less collision
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 both bits", int'(err), 3);
    do_clear();

    // R11 clear in the middle of a frame
    zero_cnt(); send_frame(8, -1, 3);
    chk("R11 skipped frame", done_cnt, 0);
    chk("R11 err", int'(err), 0);
    zero_cnt(); send_frame(6, -1, -1);
    chk("R11 next frame", last_len, 3);

    // R6 R7 random sweep
    for (int k = 0; k < 60; k++) begin
      int n;
      n = 1 + int'($urandom_range(39));
      zero_cnt(); send_frame(n, -1, -1);
      chk("R6 rand strobe", done_cnt, 1);
      chk("R6 rand len", last_len, exp_len(n));
      chk("R7 rand err", int'(err), exp_err(n));
      if (err != 2'b00) do_clear();
      repeat (int'($urandom_range(3))) drive(1'b0, 1'b0, 1'b0, 1'b0);
    end

    finish_run();
  end
endmodule